// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs one 8-bit data port in strobed mode. A host moves bytes through it, and a peripheral paces each transfer with an active-low strobe line or an active-low acknowledge line. The port works in one direction at a time, and the `dir_in` input picks that direction. Data is held in a register for both input and output.

In input mode, the falling edge of the peripheral strobe captures the port pins and raises the buffer-full status. When the input interrupt is enabled, the rising edge of the strobe raises an interrupt request. A host read of the data returns the captured byte and clears both the flag and the request.

In output mode, a host write loads the output register, pulls the active-low buffer-full line low and clears any pending request. The falling edge of the acknowledge releases the buffer-full line. When the output interrupt is enabled, the rising edge of the acknowledge raises a request.

The status lines and the request appear on fixed bits of an 8-bit control-port image. That placement depends on the `GROUP` parameter. The interrupt enables are changed only by single-bit set/reset commands that address those same control-port bit numbers. Strobe and acknowledge pass through a synchroniser of `SYNC_STAGES` flops before their edges are detected.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset, both buffer-full flags are inactive (input flag 0, active-low output flag 1), the interrupt request is 0 and both interrupt enables are 0.
- R2: The control-port image places signals by group. In group A the request is on bit 3, input-full on bit 5 and active-low output-full on bit 7. In group B the request is on bit 0 and the input-full or output-full flag is on bit 1. Each mapped bit is marked as driven in `pc_oe`: the request always, input-full only in input mode, output-full only in output mode.
- R3: In input mode, a falling strobe edge captures `port_in` into the read register and sets input-full. With `SYNC_STAGES`=2, this happens on the third rising clock after the pin falls.
- R4: In input mode, a one-cycle `host_rd` pulse clears the request and input-full at the next clock. If a strobe falling edge is detected in the same cycle, the strobe wins and input-full stays set.
- R5: A rising strobe edge (input mode) or a rising acknowledge edge (output mode) raises the request only if that direction's enable is 1 and, respectively, input-full is set or output-full is released.
- R6: An interrupt enable changes only through a set/reset command (`bsr_valid`, bit number `bsr_bit`, new value `bsr_set`). The input enable sits at the strobe bit number: 4 in group A, 2 in group B. The output enable sits at the acknowledge bit number: 6 in group A, 2 in group B. A command for any other bit number has no effect.
- R7: In output mode, a `host_wr` pulse loads `port_out`, drives output-full low and clears the request at the next clock. A later falling acknowledge edge drives output-full high again. `port_oe` is 1 in output mode and 0 in input mode.
- R8: A `host_wr` in input mode and a `host_rd` in output mode are ignored. Strobe edges in output mode and acknowledge edges in input mode are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_in | input | 1 | 1 = input direction, 0 = output direction |
| host_rd | input | 1 | One-cycle read of the input register |
| host_wr | input | 1 | One-cycle write of the output register |
| host_wdata | input | DATA_W | Data written by the host |
| host_rdata | output | DATA_W | Captured input byte |
| bsr_valid | input | 1 | Set/reset command strobe |
| bsr_bit | input | 3 | Control-port bit number addressed |
| bsr_set | input | 1 | Value written to the addressed bit |
| port_in | input | DATA_W | Data pins sampled in input mode |
| port_out | output | DATA_W | Output register contents |
| port_oe | output | 1 | Data pin drive enable |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pc_out | output | 8 | Control-port image with status and request |
| pc_oe | output | 8 | Bits of the image driven by this block |
| intr | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a request raised on a trailing edge. The enable must first be set by a command aimed at exactly the strobe or acknowledge bit number. A full low-then-high pulse must then pass through the synchroniser while the buffer flag is in the right state. The stimulus therefore runs the same pulse with the enable cleared and then with it set, and compares the request before and after the rising edge. A second instance built for group B repeats the input sequence to show the other bit placement and the shared enable bit number.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
    typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} grp_e;

    typedef struct packed {
        logic [2:0] stb;
        logic [2:0] ibf;
        logic [2:0] ack;
        logic [2:0] obf;
        logic [2:0] irq;
    } pcmap_t;

    function automatic pcmap_t pc_map(grp_e g);
        pcmap_t m;
        if (g == GRP_A) begin
            m.stb = 3'd4; m.ibf = 3'd5; m.ack = 3'd6; m.obf = 3'd7; m.irq = 3'd3;
        end else begin
            m.stb = 3'd2; m.ibf = 3'd1; m.ack = 3'd2; m.obf = 3'd1; m.irq = 3'd0;
        end
        return m;
    endfunction
endpackage

// File: rtl/hs_edge_det.sv
`timescale 1ns/1ps
module hs_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
    assign rise = ~prev_q & sync_q[STAGES-1];
endmodule

// File: rtl/hs_in_path.sv
`timescale 1ns/1ps
module hs_in_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_fall,
    input  logic         stb_rise,
    input  logic         rd,
    input  logic         inte,
    input  logic [W-1:0] pins,
    output logic [W-1:0] data,
    output logic         full,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (stb_fall) begin
                data <= pins;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (rd)
                irq <= 1'b0;
            else if (stb_rise && inte && full)
                irq <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_out_path.sv
`timescale 1ns/1ps
module hs_out_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_fall,
    input  logic         ack_rise,
    input  logic         inte,
    output logic [W-1:0] data,
    output logic         full_n,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data   <= '0;
            full_n <= 1'b1;
            irq    <= 1'b0;
        end else begin
            if (wr) begin
                data   <= wdata;
                full_n <= 1'b0;
            end else if (ack_fall) begin
                full_n <= 1'b1;
            end
            if (wr)
                irq <= 1'b0;
            else if (ack_rise && inte && full_n)
                irq <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_port_ctrl.sv
`timescale 1ns/1ps
module hs_port_ctrl #(
    parameter hs_pkg::grp_e GROUP       = hs_pkg::GRP_A,
    parameter int           DATA_W      = 8,
    parameter int           SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_in,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              bsr_valid,
    input  logic [2:0]        bsr_bit,
    input  logic              bsr_set,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic              stb_n,
    input  logic              ack_n,
    output logic [7:0]        pc_out,
    output logic [7:0]        pc_oe,
    output logic              intr
);
    import hs_pkg::*;
    localparam pcmap_t MAP = pc_map(GROUP);

    logic stb_fall_raw, stb_rise_raw, ack_fall_raw, ack_rise_raw;
    logic stb_fall, stb_rise, ack_fall, ack_rise;
    logic inte_in, inte_out;
    logic ibf, obf_n, irq_in, irq_out;

    hs_edge_det #(.STAGES(SYNC_STAGES)) u_stb (
        .clk(clk), .rst(rst), .din(stb_n), .fall(stb_fall_raw), .rise(stb_rise_raw));
    hs_edge_det #(.STAGES(SYNC_STAGES)) u_ack (
        .clk(clk), .rst(rst), .din(ack_n), .fall(ack_fall_raw), .rise(ack_rise_raw));

    assign stb_fall = stb_fall_raw & dir_in;
    assign stb_rise = stb_rise_raw & dir_in;
    assign ack_fall = ack_fall_raw & ~dir_in;
    assign ack_rise = ack_rise_raw & ~dir_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            inte_in  <= 1'b0;
            inte_out <= 1'b0;
        end else if (bsr_valid) begin
            if (bsr_bit == MAP.stb) inte_in  <= bsr_set;
            if (bsr_bit == MAP.ack) inte_out <= bsr_set;
        end
    end

    hs_in_path #(.W(DATA_W)) u_in (
        .clk(clk), .rst(rst), .stb_fall(stb_fall), .stb_rise(stb_rise),
        .rd(host_rd & dir_in), .inte(inte_in), .pins(port_in),
        .data(host_rdata), .full(ibf), .irq(irq_in));

    hs_out_path #(.W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .wr(host_wr & ~dir_in), .wdata(host_wdata),
        .ack_fall(ack_fall), .ack_rise(ack_rise), .inte(inte_out),
        .data(port_out), .full_n(obf_n), .irq(irq_out));

    assign intr    = dir_in ? irq_in : irq_out;
    assign port_oe = ~dir_in;

    always_comb begin
        pc_out = '0;
        pc_oe  = '0;
        pc_out[MAP.irq] = intr;
        pc_oe[MAP.irq]  = 1'b1;
        if (dir_in) begin
            pc_out[MAP.ibf] = ibf;
            pc_oe[MAP.ibf]  = 1'b1;
        end else begin
            pc_out[MAP.obf] = obf_n;
            pc_oe[MAP.obf]  = 1'b1;
        end
    end
endmodule

// File: rtl/hs_port_ctrl_chk.sv
`timescale 1ns/1ps
module hs_port_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic dir_in,
    input logic host_rd,
    input logic host_wr,
    input logic bsr_valid,
    input logic stb_fall,
    input logic ibf,
    input logic obf_n,
    input logic irq_in,
    input logic irq_out,
    input logic inte_in,
    input logic inte_out
);
    assert_strobe_sets_full_R3: assert property (@(posedge clk) disable iff (rst)
        stb_fall |=> ibf);
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (dir_in && host_rd && !stb_fall) |=> (!ibf && !irq_in));
    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_in) |-> $past(inte_in));
    assert_out_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(inte_out));
    assert_enable_only_by_cmd_R6: assert property (@(posedge clk) disable iff (rst)
        !bsr_valid |=> ($stable(inte_in) && $stable(inte_out)));
    assert_write_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (!dir_in && host_wr) |=> (!obf_n && !irq_out));
endmodule

bind hs_port_ctrl hs_port_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .dir_in(dir_in), .host_rd(host_rd), .host_wr(host_wr),
    .bsr_valid(bsr_valid), .stb_fall(stb_fall), .ibf(ibf), .obf_n(obf_n),
    .irq_in(irq_in), .irq_out(irq_out), .inte_in(inte_in), .inte_out(inte_out));

// File: tb/tb_hs_port_ctrl.sv
`timescale 1ns/1ps
module tb_hs_port_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic dir_in = 1'b1, host_rd = 0, host_wr = 0, bsr_valid = 0, bsr_set = 0;
    logic stb_n = 1, ack_n = 1, port_oe, intr;
    logic [2:0] bsr_bit = 0;
    logic [7:0] host_wdata = 0, host_rdata, port_in = 0, port_out, pc_out, pc_oe;

    logic b_rd = 0, b_bsr_valid = 0, b_bsr_set = 0, b_stb_n = 1, b_port_oe, b_intr;
    logic [2:0] b_bsr_bit = 0;
    logic [7:0] b_port_in = 0, b_rdata, b_port_out, b_pc_out, b_pc_oe;

    hs_port_ctrl dut (
        .clk(clk), .rst(rst), .dir_in(dir_in), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bsr_valid(bsr_valid),
        .bsr_bit(bsr_bit), .bsr_set(bsr_set), .port_in(port_in), .port_out(port_out),
        .port_oe(port_oe), .stb_n(stb_n), .ack_n(ack_n), .pc_out(pc_out),
        .pc_oe(pc_oe), .intr(intr));

    hs_port_ctrl #(.GROUP(hs_pkg::GRP_B)) dut_b (
        .clk(clk), .rst(rst), .dir_in(1'b1), .host_rd(b_rd), .host_wr(1'b0),
        .host_wdata(8'h00), .host_rdata(b_rdata), .bsr_valid(b_bsr_valid),
        .bsr_bit(b_bsr_bit), .bsr_set(b_bsr_set), .port_in(b_port_in),
        .port_out(b_port_out), .port_oe(b_port_oe), .stb_n(b_stb_n), .ack_n(1'b1),
        .pc_out(b_pc_out), .pc_oe(b_pc_oe), .intr(b_intr));

    typedef enum int {S_PC, S_PCOE, S_RDATA, S_POUT, S_INTR, S_POE, S_BPC, S_BPCOE, S_BRDATA} sel_e;
    typedef struct {
        string      req;
        sel_e       sel;
        logic [7:0] exp;
    } item_t;

    item_t sbq[$];
    event  chk_ev;
    int    checks = 0, errors = 0;
    bit    done = 0;

    function automatic logic [7:0] observe(sel_e s);
        case (s)
            S_PC:     return pc_out;
            S_PCOE:   return pc_oe;
            S_RDATA:  return host_rdata;
            S_POUT:   return port_out;
            S_INTR:   return {7'd0, intr};
            S_POE:    return {7'd0, port_oe};
            S_BPC:    return b_pc_out;
            S_BPCOE:  return b_pc_oe;
            default:  return b_rdata;
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() != 0) begin
                item_t it;
                logic [7:0] act;
                it  = sbq.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, sel_e s, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = s; it.exp = e;
        sbq.push_back(it);
        ->chk_ev;
        #0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bsr(logic [2:0] b, logic v);
        bsr_bit = b; bsr_set = v; bsr_valid = 1;
        tick(1);
        bsr_valid = 0;
    endtask

    task automatic pulse_rd();
        host_rd = 1; tick(1); host_rd = 0;
    endtask

    task automatic pulse_wr(logic [7:0] d);
        host_wdata = d; host_wr = 1; tick(1); host_wr = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        // R1 / R2: reset state, group A input placement
        expect_v("R1", S_PC, 8'h00);
        expect_v("R1", S_INTR, 8'h00);
        expect_v("R2", S_PCOE, 8'h28);
        expect_v("R7", S_POE, 8'h00);

        // R3: strobe timing, enable off
        port_in = 8'h5A; stb_n = 0;
        tick(2);
        expect_v("R3", S_PC, 8'h00);
        tick(1);
        expect_v("R3", S_PC, 8'h20);
        expect_v("R3", S_RDATA, 8'h5A);
        port_in = 8'hFF; stb_n = 1; tick(4);
        expect_v("R5", S_INTR, 8'h00);

        // R4: read clears
        pulse_rd();
        expect_v("R4", S_PC, 8'h00);

        // R6: other bit numbers do not enable; then enable at bit 4
        bsr(3'd6, 1); bsr(3'd5, 1);
        port_in = 8'h3C; stb_n = 0; tick(4); stb_n = 1; tick(4);
        expect_v("R6", S_PC, 8'h20);
        pulse_rd();
        bsr(3'd4, 1);
        port_in = 8'hC3; stb_n = 0; tick(4);
        expect_v("R5", S_PC, 8'h20);
        stb_n = 1; tick(4);
        expect_v("R5", S_PC, 8'h28);
        expect_v("R5", S_INTR, 8'h01);
        expect_v("R3", S_RDATA, 8'hC3);

        // R8: write in input mode and acknowledge ignored
        pulse_wr(8'h99);
        ack_n = 0; tick(4); ack_n = 1; tick(4);
        expect_v("R8", S_PC, 8'h28);
        expect_v("R8", S_POUT, 8'h00);

        pulse_rd();
        expect_v("R4", S_PC, 8'h00);

        // R4: read in the same cycle as a detected strobe fall keeps full
        port_in = 8'h42; stb_n = 0; tick(2);
        host_rd = 1; tick(1); host_rd = 0;
        expect_v("R4", S_PC, 8'h20);
        expect_v("R4", S_RDATA, 8'h42);
        stb_n = 1; tick(4);
        pulse_rd();
        bsr(3'd4, 0);

        // Output direction, group A
        dir_in = 0; tick(1);
        expect_v("R2", S_PCOE, 8'h88);
        expect_v("R2", S_PC, 8'h80);
        expect_v("R7", S_POE, 8'h01);
        bsr(3'd6, 1);
        pulse_rd();
        stb_n = 0; tick(4); stb_n = 1; tick(4);
        expect_v("R8", S_PC, 8'h80);
        pulse_wr(8'h77);
        expect_v("R7", S_POUT, 8'h77);
        expect_v("R7", S_PC, 8'h00);
        ack_n = 0; tick(4);
        expect_v("R7", S_PC, 8'h80);
        expect_v("R5", S_INTR, 8'h00);
        ack_n = 1; tick(4);
        expect_v("R5", S_PC, 8'h88);
        pulse_wr(8'h11);
        expect_v("R7", S_PC, 8'h00);
        expect_v("R7", S_POUT, 8'h11);

        // Group B placement, shared enable bit 2
        expect_v("R2", S_BPCOE, 8'h03);
        b_bsr_bit = 3'd2; b_bsr_set = 1; b_bsr_valid = 1; tick(1); b_bsr_valid = 0;
        b_port_in = 8'hA5; b_stb_n = 0; tick(4); b_stb_n = 1; tick(4);
        expect_v("R2", S_BPC, 8'h03);
        expect_v("R3", S_BRDATA, 8'hA5);
        b_rd = 1; tick(1); b_rd = 0;
        expect_v("R4", S_BPC, 8'h00);

        tick(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule